// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block takes a stereo serial audio stream as three pins (a bit clock running at 64 times the frame rate, a frame clock whose level tells the channel, and a serial data line) and turns it into parallel 20-bit left and right samples. The three pins come from another clock domain. A faster system clock oversamples them through a synchronizer. Each rising edge of the bit clock becomes a single one-cycle sample event. Every half frame has 32 bit slots, and a slot counter that restarts at each frame-clock transition places each slot in its half.

A 2-bit format select chooses one of four framings:

| Code | Framing | Left channel when frame clock is | Data position in the 32-slot half frame |
|---|---|---|---|
| 00 | MSB-justified, 20 bit | high | slots 0 to 19 |
| 01 | I2S, 20 bit | low | slots 1 to 20 |
| 10 | LSB-justified, 20 bit | high | slots 12 to 31 |
| 11 | LSB-justified, 16 bit | high | slots 16 to 31 |

A strap input forces the I2S framing whatever the format select holds. When a left word and the following right word have both been captured, the block presents the pair with a one-cycle valid pulse. A half frame of the wrong length raises a one-cycle framing-error pulse. The format select and the strap are meant to change only while the block is held in reset.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, valid_o and frame_err_o are 0 and left_o and right_o are all zeros.
- R2: With format 00, the left channel is the half frame with the frame clock high. The 20-bit word is MSB first in slots 0 to 19, and slot 0 is the bit sampled at the first bit-clock rise after the frame-clock transition.
- R3: With format 01, the left channel is the half frame with the frame clock low. The 20-bit word is MSB first in slots 1 to 20, so the MSB comes one bit clock after the transition.
- R4: With format 10, the left channel is the frame-clock-high half. The word sits in slots 12 to 31, and the bits in slots 0 to 11 have no effect on the output.
- R5: With format 11, the left channel is the frame-clock-high half. A 16-bit word sits in slots 16 to 31 and is output as bits 19:4, with bits 3:0 zero. Slots 0 to 15 have no effect on the output.
- R6: While force_i2s_i is 1, the receiver uses the format 01 framing for every value of fmt_i.
- R7: Exactly one valid_o pulse, one cycle long, is produced for each left half frame that is followed by its right half frame. It comes after the right word completes and carries both words. left_o and right_o change only in a cycle where valid_o is 1.
- R8: frame_err_o pulses for one cycle when a frame-clock transition ends a half frame that did not last exactly 32 slots. The first transition after reset never raises it.
- R9: After a framing error, the left word held so far is discarded, so no valid_o pulse comes until a new left word has been captured. The slot sampled at the erroneous transition is slot 0 of the new half frame.
- R10: Each rising edge of the bit clock produces exactly one sample event, and data and frame clock are taken from that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i | input | 2 | Framing select (00, 01, 10, 11 as listed above) |
| force_i2s_i | input | 1 | Strap that forces the I2S framing when 1 |
| bck_i | input | 1 | Serial bit clock, 64 times the frame rate |
| lrck_i | input | 1 | Frame clock, its level selects the channel |
| sdata_i | input | 1 | Serial data, MSB first, two's complement |
| left_o | output | 20 | Last completed left sample |
| right_o | output | 20 | Last completed right sample |
| valid_o | output | 1 | One-cycle pulse when a new stereo pair is presented |
| frame_err_o | output | 1 | One-cycle pulse on a half frame of the wrong length |

## Verification
Three things can fall on a single bit-clock event: restarting the slot counter, flagging a framing error, and capturing the MSB of the next word. In MSB-justified mode the bench sends a right half frame cut to 28 slots. The transition that ends it is then both an error and slot 0 of the next left word. The bench expects one error pulse, the valid pulse of the short frame already delivered, and correct data in the frame that follows. A second case cuts a left half in the wide LSB-justified mode and expects an error with no valid pulse for that frame.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  typedef enum logic [1:0] {
    FMT_MSB        = 2'b00,
    FMT_I2S        = 2'b01,
    FMT_LSB_WIDE   = 2'b10,
    FMT_LSB_NARROW = 2'b11
  } rx_fmt_e;
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bck_i,
  input  logic lrck_i,
  input  logic sdata_i,
  output logic evt_o,
  output logic lr_o,
  output logic dat_o
);
  localparam int LAST = STAGES - 1;

  // each stage holds {data, frame clock, bit clock}
  logic [2:0] pipe [STAGES];
  logic       bck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      bck_prev <= 1'b0;
    end else begin
      pipe[0] <= {sdata_i, lrck_i, bck_i};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      bck_prev <= pipe[LAST][0];
    end
  end

  assign evt_o = pipe[LAST][0] & ~bck_prev;
  assign lr_o  = pipe[LAST][1];
  assign dat_o = pipe[LAST][2];

  assert_single_sample_R10: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> !evt_o);
endmodule

// File: rtl/aud_rx_slot.sv
module aud_rx_slot #(
  parameter int SLOT_N = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              evt_i,
  input  logic                              lr_i,
  output logic                              edge_o,
  output logic [$clog2(2*SLOT_N)-1:0]       slot_o,
  output logic                              err_now_o,
  output logic                              err_o
);
  localparam int CNT_W   = $clog2(2*SLOT_N);
  localparam int CNT_MAX = 2*SLOT_N - 1;

  logic             lr_q, primed_q, locked_q;
  logic [CNT_W-1:0] cnt_q;

  assign edge_o    = evt_i && primed_q && (lr_i != lr_q);
  assign slot_o    = edge_o ? '0 :
                     (cnt_q == CNT_W'(CNT_MAX)) ? cnt_q : cnt_q + CNT_W'(1);
  assign err_now_o = edge_o && locked_q && (cnt_q != CNT_W'(SLOT_N-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_q     <= 1'b0;
      primed_q <= 1'b0;
      locked_q <= 1'b0;
      cnt_q    <= CNT_W'(CNT_MAX);
      err_o    <= 1'b0;
    end else begin
      err_o <= err_now_o;
      if (evt_i) begin
        primed_q <= 1'b1;
        lr_q     <= lr_i;
        cnt_q    <= slot_o;
        if (edge_o) locked_q <= 1'b1;
      end
    end
  end

  assert_slot_advance_R8: assert property (@(posedge clk) disable iff (rst)
    (evt_i && !edge_o && cnt_q != CNT_W'(CNT_MAX)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);
endmodule

// File: rtl/aud_rx_word.sv
module aud_rx_word
  import aud_rx_pkg::*;
#(
  parameter int WORD_W  = 20,
  parameter int SHORT_W = 16,
  parameter int SLOT_N  = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        evt_i,
  input  logic                        dat_i,
  input  logic                        lr_i,
  input  logic [$clog2(2*SLOT_N)-1:0] slot_i,
  input  logic                        err_now_i,
  input  logic [1:0]                  fmt_i,
  input  logic                        force_i2s_i,
  output logic [WORD_W-1:0]           left_o,
  output logic [WORD_W-1:0]           right_o,
  output logic                        valid_o
);
  localparam int CNT_W = $clog2(2*SLOT_N);
  localparam int PAD   = WORD_W - SHORT_W;

  rx_fmt_e          eff;
  logic [CNT_W-1:0] last_slot;
  logic             is_left, latch;
  logic [WORD_W-1:0] sh_q, nxt, narrow, word_now, left_hold;
  logic             left_ok;

  assign eff = force_i2s_i ? FMT_I2S : rx_fmt_e'(fmt_i);

  always_comb begin
    case (eff)
      FMT_MSB: last_slot = CNT_W'(WORD_W - 1);
      FMT_I2S: last_slot = CNT_W'(WORD_W);
      default: last_slot = CNT_W'(SLOT_N - 1);
    endcase
  end

  assign is_left = (eff == FMT_I2S) ? !lr_i : lr_i;
  assign nxt     = {sh_q[WORD_W-2:0], dat_i};
  assign latch   = evt_i && (slot_i == last_slot);

  generate
    if (PAD > 0) begin : g_pad
      assign narrow = {nxt[SHORT_W-1:0], {PAD{1'b0}}};
    end else begin : g_nopad
      assign narrow = nxt;
    end
  endgenerate

  assign word_now = (eff == FMT_LSB_NARROW) ? narrow : nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      left_hold <= '0;
      left_ok   <= 1'b0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (evt_i) sh_q <= nxt;
      if (err_now_i) left_ok <= 1'b0;
      if (latch) begin
        if (is_left) begin
          left_hold <= word_now;
          left_ok   <= 1'b1;
        end else if (left_ok) begin
          left_o  <= left_hold;
          right_o <= word_now;
          valid_o <= 1'b1;
          left_ok <= 1'b0;
        end
      end
    end
  end

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  assert_hold_words_R7: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));
  assert_valid_from_event_R10: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(evt_i));
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx #(
  parameter int WORD_W      = 20,
  parameter int SHORT_W     = 16,
  parameter int SLOT_N      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        fmt_i,
  input  logic              force_i2s_i,
  input  logic              bck_i,
  input  logic              lrck_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o,
  output logic              frame_err_o
);
  localparam int CNT_W = $clog2(2*SLOT_N);

  logic             evt, lr, dat, edge_w, err_now;
  logic [CNT_W-1:0] slot;

  aud_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bck_i(bck_i), .lrck_i(lrck_i), .sdata_i(sdata_i),
    .evt_o(evt), .lr_o(lr), .dat_o(dat)
  );

  aud_rx_slot #(.SLOT_N(SLOT_N)) u_slot (
    .clk(clk), .rst(rst), .evt_i(evt), .lr_i(lr),
    .edge_o(edge_w), .slot_o(slot), .err_now_o(err_now), .err_o(frame_err_o)
  );

  aud_rx_word #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .SLOT_N(SLOT_N)) u_word (
    .clk(clk), .rst(rst), .evt_i(evt), .dat_i(dat), .lr_i(lr), .slot_i(slot),
    .err_now_i(err_now), .fmt_i(fmt_i), .force_i2s_i(force_i2s_i),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  assert_no_err_and_valid_R9: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> !valid_o);

  logic unused_edge;
  assign unused_edge = edge_w;
endmodule

// File: tb/sim_aud_serial_rx.sv
module sim_aud_serial_rx;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt = 2'b00;
  logic        strap = 1'b0;
  logic        bck = 1'b0, lrck = 1'b0, sdata = 1'b0;
  logic [19:0] left_o, right_o;
  logic        valid_o, frame_err_o;

  int checks = 0, errors = 0;
  int nvalid = 0, nerr = 0;
  logic [19:0] got_l = '0, got_r = '0;

  always #(CLK_P/2) clk = ~clk;

  aud_serial_rx u0 (
    .clk(clk), .rst(rst), .fmt_i(fmt), .force_i2s_i(strap),
    .bck_i(bck), .lrck_i(lrck), .sdata_i(sdata),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .frame_err_o(frame_err_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (valid_o) begin
        nvalid <= nvalid + 1;
        got_l  <= left_o;
        got_r  <= right_o;
      end
      if (frame_err_o) nerr <= nerr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic slot_bit(input int ef, input logic [19:0] w, input int s);
    case (ef)
      0:       return (s < 20) ? w[19-s] : 1'b1;
      1:       return (s >= 1 && s <= 20) ? w[20-s] : 1'b1;
      2:       return (s >= 12) ? w[31-s] : 1'b1;
      default: return (s >= 16) ? w[31-s] : 1'b1;
    endcase
  endfunction

  function automatic logic [19:0] exp_word(input int ef, input logic [19:0] w);
    return (ef == 3) ? {w[15:0], 4'h0} : w;
  endfunction

  task automatic one_slot(input logic lv, input logic d);
    @(negedge clk);
    lrck  = lv;
    sdata = d;
    repeat (HALF-1) @(negedge clk);
    bck = 1'b1;
    repeat (HALF) @(negedge clk);
    bck = 1'b0;
  endtask

  task automatic send_half(input int ef, input logic lv, input logic [19:0] w, input int n);
    for (int s = 0; s < n; s++) one_slot(lv, slot_bit(ef, w, s));
  endtask

  task automatic send_frame(input int ef, input logic [19:0] l, input logic [19:0] r,
                            input int nl, input int nr);
    logic lv;
    lv = (ef == 1) ? 1'b0 : 1'b1;
    send_half(ef, lv, l, nl);
    send_half(ef, ~lv, r, nr);
    @(negedge clk);
    #1;
  endtask

  task automatic restart(input int f, input bit s);
    int ef;
    fmt   = 2'(f);
    strap = s;
    rst   = 1'b1;
    repeat (4) @(negedge clk);
    rst   = 1'b0;
    ef = s ? 1 : f;
    for (int p = 0; p < 4; p++) one_slot((ef == 1) ? 1'b1 : 1'b0, 1'b1);
  endtask

  task automatic check_pair(input string req, input int ef, input logic [19:0] l, input logic [19:0] r);
    chk({got_l, got_r} == {exp_word(ef, l), exp_word(ef, r)}, req,
        {got_l, got_r}, {exp_word(ef, l), exp_word(ef, r)});
  endtask

  initial begin
    #(CLK_P * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string req;
    int base_v, base_e;
    logic [19:0] l, r;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid", 40'(valid_o), 40'(0));
    chk(frame_err_o == 1'b0, "R1 err", 40'(frame_err_o), 40'(0));
    chk({left_o, right_o} == '0, "R1 words", {left_o, right_o}, 40'(0));
    rst = 1'b0;
    @(negedge clk);
    chk(valid_o == 1'b0 && {left_o, right_o} == '0, "R1 after release",
        {left_o, right_o}, 40'(0));

    // R2..R7 sweep over formats and strap
    for (int f = 0; f < 4; f++) begin
      for (int s = 0; s < 2; s++) begin
        int ef;
        ef = (s == 1) ? 1 : f;
        if (s == 1)      req = "R6";
        else if (f == 0) req = "R2";
        else if (f == 1) req = "R3";
        else if (f == 2) req = "R4";
        else             req = "R5";
        restart(f, s[0]);
        base_v = nvalid;
        base_e = nerr;
        for (int k = 0; k < 6; k++) begin
          if (k == 0)      begin l = 20'h80000; r = 20'h7FFFF; end
          else if (k == 1) begin l = 20'h00000; r = 20'hFFFFF; end
          else begin
            l = 20'((k * 32'h2F1B3) + (f * 32'h5A5) + s * 7);
            r = 20'((k * 32'h1C0DF) ^ (f * 32'h3C3C3) ^ 32'hA5A5A);
          end
          send_frame(ef, l, r, 32, 32);
          chk(nvalid == base_v + k + 1, "R7 one valid per frame",
              40'(nvalid), 40'(base_v + k + 1));
          check_pair(req, ef, l, r);
        end
        chk(nerr == base_e, "R8 no false error", 40'(nerr), 40'(base_e));
      end
    end

    // R8/R9: short right half in MSB format; error edge carries next MSB
    restart(0, 1'b0);
    base_v = nvalid;
    base_e = nerr;
    send_frame(0, 20'h12345, 20'hABCDE, 32, 32);
    check_pair("R2 before error", 0, 20'h12345, 20'hABCDE);
    send_frame(0, 20'h0F0F0, 20'h9A5C3, 32, 28);
    chk(nvalid == base_v + 2, "R7 short right still valid", 40'(nvalid), 40'(base_v + 2));
    check_pair("R7 short right data", 0, 20'h0F0F0, 20'h9A5C3);
    send_frame(0, 20'hFEDCB, 20'h00F01, 32, 32);
    chk(nerr == base_e + 1, "R8 error on short right", 40'(nerr), 40'(base_e + 1));
    chk(nvalid == base_v + 3, "R9 frame after error valid", 40'(nvalid), 40'(base_v + 3));
    check_pair("R9 slot0 at error edge", 0, 20'hFEDCB, 20'h00F01);

    // R8/R9: short left half in wide LSB format drops the frame
    restart(2, 1'b0);
    base_v = nvalid;
    base_e = nerr;
    send_frame(2, 20'h11111, 20'h22222, 30, 32);
    chk(nerr == base_e + 1, "R8 error on short left", 40'(nerr), 40'(base_e + 1));
    chk(nvalid == base_v, "R9 no valid after error", 40'(nvalid), 40'(base_v));
    send_frame(2, 20'h3C5A7, 20'hC3A58, 32, 32);
    chk(nvalid == base_v + 1, "R9 recovery valid", 40'(nvalid), 40'(base_v + 1));
    check_pair("R9 recovery data", 2, 20'h3C5A7, 20'hC3A58);
    chk(nerr == base_e + 1, "R8 single error", 40'(nerr), 40'(base_e + 1));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule